// File: doc/BRIEF.md
# Extended Arithmetic Sequencer

This block is a multi-cycle arithmetic unit for a 12-bit accumulator machine. It works on four architectural registers: a link bit, a 12-bit accumulator (AC), a 12-bit multiplier-quotient register (MQ) and a 5-bit step counter (SC). When a start pulse arrives, the unit captures the current register values and the 12-bit operand word that follows the instruction. It applies the instruction's micro-operations and then runs the selected arithmetic operation. Multiply, divide and the shift family take one step per clock.

Register values are taken from the `*_i` inputs on the start pulse. They are updated in place and presented on the `*_o` outputs. The outputs are final when `done_o` pulses. The surrounding core copies the results back into its own register file. A start pulse that arrives while the unit is busy has no effect.

Top module: `eae_unit`

## Requirements
- R1: `instr_i[7]` clears AC first. Then `instr_i[6]` and `instr_i[4]` select a transfer:
  - 6 alone ORs MQ into AC.
  - 4 alone copies AC into MQ and clears AC.
  - Both together swap AC and MQ.
  - The link is not touched by these micro-operations.
- R2: `instr_i[5]` ORs the zero-extended SC into AC after the transfer and before the operation runs.
- R3: `instr_i[3:1]` selects the operation: 0 none, 1 load SC, 2 multiply, 3 divide, 4 normalize, 5 shift left, 6 arithmetic shift right, 7 logical shift right. Load SC sets SC to the bitwise inverse of `operand_i[4:0]`.
- R4: Multiply leaves MQ×operand+AC in {AC,MQ} (AC holds the upper half) and clears the link.
- R5: Divide with a nonzero operand and AC < operand puts {AC,MQ}/operand in MQ and the remainder in AC, and clears the link.
- R6: Divide with a zero operand or AC ≥ operand sets the link, leaves AC unchanged, sets MQ to (2×{AC,MQ} mod 4096)+1 and sets SC to 31.
- R7: Normalize clears SC. It then shifts {AC,MQ} left while the value is nonzero and its two top bits are equal, adding one to SC per shift. The link receives each bit shifted out of AC bit 11.
- R8: Shift left moves {AC,MQ} left by min(operand+1, 31) places and fills with zeros. The link ends holding the last bit shifted out of AC bit 11.
- R9: Arithmetic shift right moves {AC,MQ} right by min(operand+1, 31) places, filling with AC bit 11, and sets the link to that sign bit. Logical shift right fills with zeros and clears the link.
- R10: The step count N is 12 for multiply and a non-overflowing divide, the shift distance for shifts, the number of shifts for normalize, and 0 otherwise.
  - `busy_o` rises at the edge that samples start.
  - `done_o` rises N+1 edges later and is high for exactly one cycle.
  - `busy_o` falls on the same edge that raises `done_o`.
- R11: A start pulse while `busy_o` is high changes neither the result nor the latency.
- R12: After reset, all register outputs, `busy_o` and `done_o` are zero.
- R13: While the unit is idle and start is low, the register outputs hold their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| instr_i | input | 7 | Instruction bits 7:1 |
| operand_i | input | 12 | Operand word following the instruction |
| link_i | input | 1 | Link value to capture |
| ac_i | input | 12 | Accumulator value to capture |
| mq_i | input | 12 | Multiplier-quotient value to capture |
| sc_i | input | 5 | Step counter value to capture |
| link_o | output | 1 | Link result |
| ac_o | output | 12 | Accumulator result |
| mq_o | output | 12 | Multiplier-quotient result |
| sc_o | output | 5 | Step counter result |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every step updates the visible registers, so a corrupted step counter or a wrong operation code shows at the ports within one result. It appears as `done_o` arriving a cycle early or late, and as {AC,MQ} shifted by the wrong distance. A wrong quotient bit or a wrong partial-sum bit changes MQ or AC at the completion pulse, at most 32 cycles after start.

The bench measures the latency of every operation against the expected step count. It injects a start pulse in mid-operation. It also disturbs the data inputs while the unit is idle, so that a missing guard shows up in the held outputs.

// File: rtl/eae_pkg.sv
package eae_pkg;
  localparam int unsigned WORD_W_DEF = 12;
  localparam int unsigned CNT_W_DEF  = 5;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SCL  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_NORM = 3'd4,
    OP_SHL  = 3'd5,
    OP_ASR  = 3'd6,
    OP_LSR  = 3'd7
  } eae_op_e;
endpackage

// File: rtl/eae_front.sv
// Start-time micro-operations and per-operation setup.
module eae_front
  import eae_pkg::*;
#(
  parameter int unsigned W  = WORD_W_DEF,
  parameter int unsigned CW = CNT_W_DEF
) (
  input  logic [7:1]    instr_i,
  input  logic [W-1:0]  operand_i,
  input  logic          link_i,
  input  logic [W-1:0]  ac_i,
  input  logic [W-1:0]  mq_i,
  input  logic [CW-1:0] sc_i,
  output eae_op_e       op_o,
  output logic          link_o,
  output logic [W-1:0]  ac_o,
  output logic [W-1:0]  mq_o,
  output logic [CW-1:0] sc_o,
  output logic [CW-1:0] steps_o
);
  localparam int unsigned MAX_SH = (1 << CW) - 1;

  logic [W-1:0]  ac_clr, ac_xfer, mq_xfer, ac_pre;
  logic [CW-1:0] sh_cnt;
  logic          div_ovf;

  always_comb begin
    ac_clr = instr_i[7] ? '0 : ac_i;
    unique case ({instr_i[6], instr_i[4]})
      2'b10:   begin ac_xfer = ac_clr | mq_i; mq_xfer = mq_i;   end
      2'b01:   begin ac_xfer = '0;            mq_xfer = ac_clr; end
      2'b11:   begin ac_xfer = mq_i;          mq_xfer = ac_clr; end
      default: begin ac_xfer = ac_clr;        mq_xfer = mq_i;   end
    endcase
    ac_pre = instr_i[5] ? (ac_xfer | W'(sc_i)) : ac_xfer;
  end

  assign op_o    = eae_op_e'(instr_i[3:1]);
  assign sh_cnt  = (operand_i >= W'(MAX_SH - 1)) ? CW'(MAX_SH)
                                                 : operand_i[CW-1:0] + CW'(1);
  assign div_ovf = (operand_i == '0) || (ac_pre >= operand_i);

  always_comb begin
    link_o  = link_i;
    ac_o    = ac_pre;
    mq_o    = mq_xfer;
    sc_o    = sc_i;
    steps_o = '0;
    case (op_o)
      OP_SCL: sc_o = ~operand_i[CW-1:0];
      OP_MUL: begin
        link_o  = 1'b0;
        steps_o = CW'(W);
      end
      OP_DIV: begin
        if (div_ovf) begin
          link_o = 1'b1;
          mq_o   = {mq_xfer[W-2:0], 1'b1};
          sc_o   = '1;
        end else begin
          link_o  = 1'b0;
          steps_o = CW'(W);
        end
      end
      OP_NORM: sc_o = '0;
      OP_SHL:  steps_o = sh_cnt;
      OP_ASR: begin
        link_o  = ac_pre[W-1];
        steps_o = sh_cnt;
      end
      OP_LSR: begin
        link_o  = 1'b0;
        steps_o = sh_cnt;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eae_step.sv
// One clock's worth of progress for the iterative operations.
module eae_step
  import eae_pkg::*;
#(
  parameter int unsigned W  = WORD_W_DEF,
  parameter int unsigned CW = CNT_W_DEF
) (
  input  eae_op_e       op_i,
  input  logic [W-1:0]  operand_i,
  input  logic          link_i,
  input  logic [W-1:0]  ac_i,
  input  logic [W-1:0]  mq_i,
  input  logic [CW-1:0] sc_i,
  output logic          link_o,
  output logic [W-1:0]  ac_o,
  output logic [W-1:0]  mq_o,
  output logic [CW-1:0] sc_o,
  output logic          norm_done_o
);
  logic [W:0] sum, part, diff;
  logic       fits;

  // multiply: add-and-shift-right, AC seeds the upper half as addend
  assign sum  = {1'b0, ac_i} + (mq_i[0] ? {1'b0, operand_i} : {(W+1){1'b0}});
  // divide: restoring subtract on the partial remainder
  assign part = {ac_i, mq_i[W-1]};
  assign diff = part - {1'b0, operand_i};
  assign fits = part >= {1'b0, operand_i};

  assign norm_done_o = ({ac_i, mq_i} == '0) || (ac_i[W-1] != ac_i[W-2]);

  always_comb begin
    link_o = link_i;
    ac_o   = ac_i;
    mq_o   = mq_i;
    sc_o   = sc_i;
    case (op_i)
      OP_MUL: begin
        ac_o = sum[W:1];
        mq_o = {sum[0], mq_i[W-1:1]};
      end
      OP_DIV: begin
        ac_o = fits ? diff[W-1:0] : part[W-1:0];
        mq_o = {mq_i[W-2:0], fits};
      end
      OP_NORM: begin
        {link_o, ac_o, mq_o} = {ac_i, mq_i, 1'b0};
        sc_o = sc_i + CW'(1);
      end
      OP_SHL: {link_o, ac_o, mq_o} = {ac_i, mq_i, 1'b0};
      OP_ASR: {ac_o, mq_o} = {ac_i[W-1], ac_i, mq_i[W-1:1]};
      OP_LSR: {ac_o, mq_o} = {1'b0, ac_i, mq_i[W-1:1]};
      default: ;
    endcase
  end
endmodule

// File: rtl/eae_unit.sv
module eae_unit
  import eae_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:1]        instr_i,
  input  logic [WORD_W-1:0] operand_i,
  input  logic              link_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic [WORD_W-1:0] mq_i,
  input  logic [CNT_W-1:0]  sc_i,
  output logic              link_o,
  output logic [WORD_W-1:0] ac_o,
  output logic [WORD_W-1:0] mq_o,
  output logic [CNT_W-1:0]  sc_o,
  output logic              busy_o,
  output logic              done_o
);
  eae_op_e           f_op, op_q;
  logic              f_link, s_link, link_q;
  logic [WORD_W-1:0] f_ac, f_mq, s_ac, s_mq, ac_q, mq_q, opd_q;
  logic [CNT_W-1:0]  f_sc, s_sc, sc_q, f_steps, cnt_q;
  logic              s_norm_done, busy_q, done_q, finish;

  eae_front #(.W(WORD_W), .CW(CNT_W)) i_front (
    .instr_i   (instr_i),
    .operand_i (operand_i),
    .link_i    (link_i),
    .ac_i      (ac_i),
    .mq_i      (mq_i),
    .sc_i      (sc_i),
    .op_o      (f_op),
    .link_o    (f_link),
    .ac_o      (f_ac),
    .mq_o      (f_mq),
    .sc_o      (f_sc),
    .steps_o   (f_steps)
  );

  eae_step #(.W(WORD_W), .CW(CNT_W)) i_step (
    .op_i        (op_q),
    .operand_i   (opd_q),
    .link_i      (link_q),
    .ac_i        (ac_q),
    .mq_i        (mq_q),
    .sc_i        (sc_q),
    .link_o      (s_link),
    .ac_o        (s_ac),
    .mq_o        (s_mq),
    .sc_o        (s_sc),
    .norm_done_o (s_norm_done)
  );

  assign finish = (op_q == OP_NORM) ? s_norm_done : (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b0;
      ac_q   <= '0;
      mq_q   <= '0;
      sc_q   <= '0;
      opd_q  <= '0;
      op_q   <= OP_NONE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          link_q <= f_link;
          ac_q   <= f_ac;
          mq_q   <= f_mq;
          sc_q   <= f_sc;
          opd_q  <= operand_i;
          op_q   <= f_op;
          cnt_q  <= f_steps;
          busy_q <= 1'b1;
        end
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        link_q <= s_link;
        ac_q   <= s_ac;
        mq_q   <= s_mq;
        sc_q   <= s_sc;
        if (op_q != OP_NORM) cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign link_o = link_q;
  assign ac_o   = ac_q;
  assign mq_o   = mq_q;
  assign sc_o   = sc_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/eae_unit_chk.sv
module eae_unit_chk #(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [7:1]    instr_i,
  input logic [W-1:0]  operand_i,
  input logic          link_o,
  input logic [W-1:0]  ac_o,
  input logic [W-1:0]  mq_o,
  input logic [CW-1:0] sc_o,
  input logic          busy_o,
  input logic          done_o
);
  a_r10_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r10_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  a_r3_scl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && instr_i[3:1] == 3'd1) |=> (sc_o == ~$past(operand_i[CW-1:0])));

  a_r6_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && instr_i[3:1] == 3'd3 && operand_i == '0)
      |=> (link_o && sc_o == '1 && mq_o[0]));

  a_r13_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(ac_o) && $stable(mq_o) && $stable(link_o) && $stable(sc_o)));
endmodule

bind eae_unit eae_unit_chk #(.W(WORD_W), .CW(CNT_W)) i_eae_unit_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .instr_i   (instr_i),
  .operand_i (operand_i),
  .link_o    (link_o),
  .ac_o      (ac_o),
  .mq_o      (mq_o),
  .sc_o      (sc_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/test_eae_unit.sv
module test_eae_unit;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:1]  instr = '0;
  logic [11:0] opd = '0, ac_in = '0, mq_in = '0;
  logic        lk_in = 1'b0;
  logic [4:0]  sc_in = '0;
  logic        link_o, busy_o, done_o;
  logic [11:0] ac_o, mq_o;
  logic [4:0]  sc_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  eae_unit i_eae_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .operand_i(opd), .link_i(lk_in), .ac_i(ac_in), .mq_i(mq_in), .sc_i(sc_in),
    .link_o(link_o), .ac_o(ac_o), .mq_o(mq_o), .sc_o(sc_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  task automatic model(input logic [7:0] ins, input logic lk, input logic [11:0] a, input logic [11:0] m,
                       input logic [4:0] s, input logic [11:0] o,
                       output logic e_lk, output logic [11:0] e_ac, output logic [11:0] e_mq,
                       output logic [4:0] e_sc, output int e_steps);
    logic [11:0] t;
    logic [31:0] d, q, r;
    logic [23:0] v;
    logic signed [23:0] sv;
    int n;
    e_lk = lk; e_ac = ins[7] ? 12'o0 : a; e_mq = m; e_sc = s; e_steps = 0;
    if (ins[6] && ins[4]) begin t = e_ac; e_ac = m; e_mq = t; end
    else if (ins[6]) e_ac = e_ac | m;
    else if (ins[4]) begin e_mq = e_ac; e_ac = 12'o0; end
    if (ins[5]) e_ac = e_ac | {7'd0, s};
    n = (o >= 12'd30) ? 31 : int'(o) + 1;
    v = {e_ac, e_mq};
    case (ins[3:1])
      3'd1: e_sc = ~o[4:0];
      3'd2: begin
        d = e_mq * o + e_ac;
        e_ac = d[23:12]; e_mq = d[11:0]; e_lk = 1'b0; e_steps = 12;
      end
      3'd3: begin
        d = {8'd0, e_ac, e_mq};
        if (o == 12'o0 || d / o > 32'd4095) begin
          e_lk = 1'b1; e_mq = {e_mq[10:0], 1'b1}; e_sc = 5'd31;
        end else begin
          q = d / o; r = d % o;
          e_mq = q[11:0]; e_ac = r[11:0]; e_lk = 1'b0; e_steps = 12;
        end
      end
      3'd4: begin
        e_sc = 5'd0;
        while (v != 24'd0 && v[23] == v[22]) begin
          e_lk = v[23]; v = v << 1; e_sc = e_sc + 5'd1; e_steps++;
        end
        e_ac = v[23:12]; e_mq = v[11:0];
      end
      3'd5: begin
        for (int i = 0; i < n; i++) begin e_lk = v[23]; v = v << 1; end
        e_ac = v[23:12]; e_mq = v[11:0]; e_steps = n;
      end
      3'd6: begin
        sv = $signed(v) >>> n;
        e_lk = e_ac[11]; e_ac = sv[23:12]; e_mq = sv[11:0]; e_steps = n;
      end
      3'd7: begin
        v = v >> n;
        e_lk = 1'b0; e_ac = v[23:12]; e_mq = v[11:0]; e_steps = n;
      end
      default: ;
    endcase
  endtask

  // One scenario: run an instruction, check latency and every register (R10 on all).
  task automatic run_op(input string req, input logic [7:0] ins, input logic lk, input logic [11:0] a,
                        input logic [11:0] m, input logic [4:0] s, input logic [11:0] o, input bit poke);
    logic e_lk; logic [11:0] e_ac, e_mq; logic [4:0] e_sc; int e_steps; int k;
    model(ins, lk, a, m, s, o, e_lk, e_ac, e_mq, e_sc, e_steps);
    @(negedge clk);
    instr = ins[7:1]; lk_in = lk; ac_in = a; mq_in = m; sc_in = s; opd = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0; k = 0;
    chk("R10", "busy after start", 32'(busy_o), 1);
    while (!done_o && k < 80) begin
      if (poke && k == 2) begin  // R11: start while busy
        start = 1'b1; instr = 7'b0000001; ac_in = ~a; opd = ~o; lk_in = ~lk;
      end
      @(negedge clk);
      start = 1'b0; k++;
    end
    chk(req, "latency", k, e_steps + 1);
    chk("R10", "busy at done", 32'(busy_o), 0);
    chk(req, "link", 32'(link_o), 32'(e_lk));
    chk(req, "ac", 32'(ac_o), 32'(e_ac));
    chk(req, "mq", 32'(mq_o), 32'(e_mq));
    chk(req, "sc", 32'(sc_o), 32'(e_sc));
    @(negedge clk);
    chk("R10", "done one cycle", 32'(done_o), 0);
  endtask

  task automatic idle_hold();
    logic l0; logic [11:0] a0, m0; logic [4:0] s0;
    l0 = link_o; a0 = ac_o; m0 = mq_o; s0 = sc_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ac_in = ac_in + 12'o1357; mq_in = ~mq_in; lk_in = ~lk_in; sc_in = sc_in + 5'd7;
      opd = opd + 12'o3; instr = ~instr;
    end
    @(negedge clk);
    chk("R13", "ac held", 32'(ac_o), 32'(a0));
    chk("R13", "mq held", 32'(mq_o), 32'(m0));
    chk("R13", "link held", 32'(link_o), 32'(l0));
    chk("R13", "sc held", 32'(sc_o), 32'(s0));
    chk("R13", "still idle", 32'(busy_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "ac", 32'(ac_o), 0);
    chk("R12", "mq", 32'(mq_o), 0);
    chk("R12", "link", 32'(link_o), 0);
    chk("R12", "sc", 32'(sc_o), 0);
    chk("R12", "busy", 32'(busy_o), 0);
    chk("R12", "done", 32'(done_o), 0);
    rst_n = 1'b1;

    // R1 micro-operations
    run_op("R1", 8'o200, 1'b1, 12'o1234, 12'o4321, 5'd3, 12'o0, 1'b0);
    run_op("R1", 8'o100, 1'b0, 12'o1200, 12'o0034, 5'd3, 12'o0, 1'b0);
    run_op("R1", 8'o020, 1'b1, 12'o5555, 12'o1111, 5'd3, 12'o0, 1'b0);
    run_op("R1", 8'o120, 1'b0, 12'o7001, 12'o0107, 5'd3, 12'o0, 1'b0);
    run_op("R1", 8'o320, 1'b1, 12'o7001, 12'o0107, 5'd3, 12'o0, 1'b0);
    // R2 step counter OR
    run_op("R2", 8'o040, 1'b0, 12'o4400, 12'o0, 5'd21, 12'o0, 1'b0);
    run_op("R2", 8'o260, 1'b0, 12'o4400, 12'o0002, 5'd5, 12'o0, 1'b0);
    // R3 load step counter
    run_op("R3", 8'o002, 1'b0, 12'o0, 12'o0, 5'd0, 12'o7765, 1'b0);
    run_op("R3", 8'o002, 1'b1, 12'o17, 12'o1, 5'd31, 12'o0040, 1'b0);
    // R4 multiply
    run_op("R4", 8'o004, 1'b1, 12'o1234, 12'o0567, 5'd2, 12'o0321, 1'b0);
    run_op("R4", 8'o004, 1'b0, 12'o7777, 12'o7777, 5'd0, 12'o7777, 1'b0);
    run_op("R4", 8'o024, 1'b0, 12'o0025, 12'o7777, 5'd0, 12'o0100, 1'b0);
    run_op("R4", 8'o004, 1'b0, 12'o0, 12'o0, 5'd0, 12'o0, 1'b0);
    // R5 divide
    run_op("R5", 8'o006, 1'b1, 12'o0123, 12'o4567, 5'd9, 12'o0345, 1'b0);
    run_op("R5", 8'o006, 1'b0, 12'o0, 12'o7777, 5'd0, 12'o0001, 1'b0);
    run_op("R5", 8'o006, 1'b0, 12'o0344, 12'o7777, 5'd0, 12'o0345, 1'b0);
    // R6 divide overflow
    run_op("R6", 8'o006, 1'b0, 12'o0005, 12'o4001, 5'd2, 12'o0, 1'b0);
    run_op("R6", 8'o006, 1'b0, 12'o0100, 12'o2345, 5'd2, 12'o0100, 1'b0);
    // R7 normalize
    run_op("R7", 8'o010, 1'b1, 12'o0, 12'o0, 5'd7, 12'o0, 1'b0);
    run_op("R7", 8'o010, 1'b0, 12'o0, 12'o0001, 5'd7, 12'o0, 1'b0);
    run_op("R7", 8'o010, 1'b0, 12'o7777, 12'o7777, 5'd0, 12'o0, 1'b0);
    run_op("R7", 8'o010, 1'b1, 12'o2000, 12'o0, 5'd4, 12'o0, 1'b0);
    run_op("R7", 8'o010, 1'b0, 12'o7400, 12'o1234, 5'd4, 12'o0, 1'b0);
    // R8 shift left, including the cap
    run_op("R8", 8'o012, 1'b0, 12'o4321, 12'o7654, 5'd1, 12'o0, 1'b0);
    run_op("R8", 8'o012, 1'b0, 12'o0012, 12'o3456, 5'd1, 12'o0013, 1'b0);
    run_op("R8", 8'o012, 1'b1, 12'o0001, 12'o0001, 5'd1, 12'd29, 1'b0);
    run_op("R8", 8'o012, 1'b1, 12'o7777, 12'o7777, 5'd1, 12'd30, 1'b0);
    run_op("R8", 8'o012, 1'b1, 12'o7777, 12'o7777, 5'd1, 12'o7777, 1'b0);
    // R9 right shifts
    run_op("R9", 8'o014, 1'b0, 12'o4070, 12'o0707, 5'd1, 12'o0004, 1'b0);
    run_op("R9", 8'o014, 1'b1, 12'o3070, 12'o0707, 5'd1, 12'o0004, 1'b0);
    run_op("R9", 8'o014, 1'b0, 12'o4000, 12'o0, 5'd1, 12'o7777, 1'b0);
    run_op("R9", 8'o016, 1'b1, 12'o4070, 12'o0707, 5'd1, 12'o0004, 1'b0);
    run_op("R9", 8'o016, 1'b1, 12'o7777, 12'o7777, 5'd1, 12'd25, 1'b0);
    // R11 start while busy is ignored
    run_op("R11", 8'o004, 1'b0, 12'o1234, 12'o0567, 5'd0, 12'o0321, 1'b1);
    run_op("R11", 8'o012, 1'b1, 12'o0012, 12'o3456, 5'd3, 12'o0007, 1'b1);
    // R13 idle hold
    idle_hold();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule